// File: doc/BRIEF.md
# Sensed Dead-Time Gate Sequencer

This block sits between a PWM generator and the two gate drivers of a synchronous buck half-bridge. It converts a single PWM request bit into a high-side enable and a low-side enable that are never asserted together. When the requested side changes, the block first drops the enable that is on. It then waits for an external comparator to report that this gate has actually fallen below its threshold. After that it counts a fixed number of clock cycles and only then raises the other enable. The dead time therefore adapts to how slowly each gate really discharges. It is not a blind delay measured from the command edge.

Two override inputs sit above the PWM request. A shutdown input drops both enables and holds them low. A clamp input, used when the output overshoots, forces the low side on and the high side off. The clamp still goes through the same sensed hand-off. If a gate never reports low within a timeout window, the block parks both enables low and latches a stuck-gate status until reset. A 0% or 100% request holds one side on indefinitely.

Top module: `gate_handoff`

## Requirements
- R1: `hs_en` and `ls_en` are never both high in the same cycle.
- R2: When the high side is requested (`pwm_req`=1 and `clamp_ls`=0) while the low side is on, `ls_en` falls at the next edge. `hs_en` then rises exactly `DEAD_CYC` edges after the edge at which `ls_gate_low` is first sampled high in that wait.
- R3: When the low side is requested while the high side is on, `hs_en` falls at the next edge. `ls_en` then rises exactly `DEAD_CYC` edges after the edge at which `hs_gate_low` is first sampled high in that wait.
- R4: At the edge after `kill` is sampled high, both enables are low, and they stay low while `kill` is held. After release, the requested side is reached only through the full sensed hand-off of R2/R3.
- R5: A request held constant (100% or 0% duty) keeps the same enable high for any number of cycles, without toggling.
- R6: While `clamp_ls` is high it overrides `pwm_req`. `hs_en` is low at the next edge, and `ls_en` is raised through the R3 hand-off.
- R7: If the request reverses while waiting for a gate-low flag or while counting dead time, the count is abandoned. The hand-off toward the new side starts from its beginning.
- R8: If the awaited gate-low flag stays low for `TIMEOUT_CYC` consecutive edges after the wait begins, `stuck` goes high and both enables go low. This state holds, whatever the inputs do, until reset. A flag that arrives on the edge just before the limit avoids the fault.
- R9: Reset is synchronous and active-high. The edge that samples it drives both enables and `stuck` low. The first transition after reset always uses the sensed hand-off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_req | input | 1 | PWM command: 1 requests high side, 0 requests low side |
| hs_gate_low | input | 1 | High-side gate sensed below threshold |
| ls_gate_low | input | 1 | Low-side gate sensed below threshold |
| kill | input | 1 | Force both enables off while high |
| clamp_ls | input | 1 | Force low side on (over-voltage clamp) |
| hs_en | output | 1 | High-side gate enable (registered) |
| ls_en | output | 1 | Low-side gate enable (registered) |
| stuck | output | 1 | Sticky stuck-gate status (registered) |

## Verification
The main sequence is run with gate-low flags that arrive late, with flags already high when the wait starts, and with a request that flips in the middle of the dead-time count. The late flags show that the count is anchored to the sensed edge and not to the command edge. The pre-asserted flags give the minimum hand-off latency. The mid-count flip shows that a stale count is abandoned. The clamp and shutdown inputs are applied both while a side is on and while the block is idle, to separate override priority from normal sequencing. A flag held low up to one cycle short of the timeout, and one held past it, mark the exact fault boundary. Long constant requests confirm that neither side toggles at 0% or 100% duty.

// File: rtl/gate_handoff_pkg.sv
package gate_handoff_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_WAIT_LS = 3'd1,  // low side dropped, awaiting its low flag
    ST_DEAD_HS = 3'd2,  // counting dead time before high side
    ST_HS_ON   = 3'd3,
    ST_WAIT_HS = 3'd4,  // high side dropped, awaiting its low flag
    ST_DEAD_LS = 3'd5,  // counting dead time before low side
    ST_LS_ON   = 3'd6,
    ST_FAULT   = 3'd7
  } seq_state_t;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/gate_handoff_target.sv
module gate_handoff_target (
  input  logic pwm_req,
  input  logic clamp_ls,
  output logic want_hs
);
  // Clamp overrides the PWM command and always selects the low side.
  always_comb want_hs = pwm_req & ~clamp_ls;
endmodule

// File: rtl/gate_handoff_counter.sv
module gate_handoff_counter #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/gate_handoff_fsm.sv
module gate_handoff_fsm
  import gate_handoff_pkg::*;
#(
  parameter int DEAD_CYC    = 4,
  parameter int TIMEOUT_CYC = 64,
  parameter int CW          = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          want_hs,
  input  logic          hs_gate_low,
  input  logic          ls_gate_low,
  input  logic          kill,
  input  logic [CW-1:0] cnt,
  output logic          cnt_clr,
  output logic          cnt_inc,
  output seq_state_t    nxt
);
  localparam logic [CW-1:0] DEAD_LAST = CW'(DEAD_CYC - 1);
  localparam logic [CW-1:0] TO_LAST   = CW'(TIMEOUT_CYC - 1);

  seq_state_t st;

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= nxt;
  end

  always_comb begin
    nxt     = st;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    unique case (st)
      ST_IDLE: begin
        cnt_clr = 1'b1;
        nxt     = want_hs ? ST_WAIT_LS : ST_WAIT_HS;
      end
      ST_WAIT_LS: begin
        if (!want_hs) begin
          nxt = ST_WAIT_HS; cnt_clr = 1'b1;
        end else if (ls_gate_low) begin
          nxt = ST_DEAD_HS; cnt_clr = 1'b1;
        end else if (cnt == TO_LAST) begin
          nxt = ST_FAULT;
        end else begin
          cnt_inc = 1'b1;
        end
      end
      ST_WAIT_HS: begin
        if (want_hs) begin
          nxt = ST_WAIT_LS; cnt_clr = 1'b1;
        end else if (hs_gate_low) begin
          nxt = ST_DEAD_LS; cnt_clr = 1'b1;
        end else if (cnt == TO_LAST) begin
          nxt = ST_FAULT;
        end else begin
          cnt_inc = 1'b1;
        end
      end
      ST_DEAD_HS: begin
        if (!want_hs) begin
          nxt = ST_WAIT_HS; cnt_clr = 1'b1;
        end else if (cnt == DEAD_LAST) begin
          nxt = ST_HS_ON; cnt_clr = 1'b1;
        end else begin
          cnt_inc = 1'b1;
        end
      end
      ST_DEAD_LS: begin
        if (want_hs) begin
          nxt = ST_WAIT_LS; cnt_clr = 1'b1;
        end else if (cnt == DEAD_LAST) begin
          nxt = ST_LS_ON; cnt_clr = 1'b1;
        end else begin
          cnt_inc = 1'b1;
        end
      end
      ST_HS_ON: begin
        if (!want_hs) begin
          nxt = ST_WAIT_HS; cnt_clr = 1'b1;
        end
      end
      ST_LS_ON: begin
        if (want_hs) begin
          nxt = ST_WAIT_LS; cnt_clr = 1'b1;
        end
      end
      default: nxt = ST_FAULT;
    endcase
    // Shutdown wins over everything except a latched fault.
    if (kill && st != ST_FAULT) begin
      nxt     = ST_IDLE;
      cnt_clr = 1'b1;
      cnt_inc = 1'b0;
    end
  end
endmodule

// File: rtl/gate_handoff.sv
module gate_handoff
  import gate_handoff_pkg::*;
#(
  parameter int DEAD_CYC    = 4,
  parameter int TIMEOUT_CYC = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic pwm_req,
  input  logic hs_gate_low,
  input  logic ls_gate_low,
  input  logic kill,
  input  logic clamp_ls,
  output logic hs_en,
  output logic ls_en,
  output logic stuck
);
  localparam int MAXC = max_of(DEAD_CYC, TIMEOUT_CYC);
  localparam int CW   = $clog2(MAXC + 1);

  logic          want_hs;
  logic          cnt_clr;
  logic          cnt_inc;
  logic [CW-1:0] cnt;
  seq_state_t    nxt;

  gate_handoff_target u_target (
    .pwm_req (pwm_req),
    .clamp_ls(clamp_ls),
    .want_hs (want_hs)
  );

  gate_handoff_counter #(.CW(CW)) u_cnt (
    .clk(clk),
    .rst(rst),
    .clr(cnt_clr),
    .inc(cnt_inc),
    .cnt(cnt)
  );

  gate_handoff_fsm #(
    .DEAD_CYC   (DEAD_CYC),
    .TIMEOUT_CYC(TIMEOUT_CYC),
    .CW         (CW)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .want_hs    (want_hs),
    .hs_gate_low(hs_gate_low),
    .ls_gate_low(ls_gate_low),
    .kill       (kill),
    .cnt        (cnt),
    .cnt_clr    (cnt_clr),
    .cnt_inc    (cnt_inc),
    .nxt        (nxt)
  );

  // Outputs are flops loaded from the next-state decode, so they
  // change on the same edge as the state register and never glitch.
  always_ff @(posedge clk) begin
    if (rst) begin
      hs_en <= 1'b0;
      ls_en <= 1'b0;
      stuck <= 1'b0;
    end else begin
      hs_en <= (nxt == ST_HS_ON);
      ls_en <= (nxt == ST_LS_ON);
      stuck <= (nxt == ST_FAULT);
    end
  end
endmodule

// File: rtl/gate_handoff_chk.sv
module gate_handoff_chk (
  input logic clk,
  input logic rst,
  input logic pwm_req,
  input logic hs_gate_low,
  input logic ls_gate_low,
  input logic kill,
  input logic clamp_ls,
  input logic hs_en,
  input logic ls_en,
  input logic stuck
);
  // Tracks whether each gate has been sensed low since its enable last dropped.
  logic hs_seen, ls_seen;
  always_ff @(posedge clk) begin
    if (rst) begin
      hs_seen <= 1'b0;
      ls_seen <= 1'b0;
    end else begin
      if (hs_en)            hs_seen <= 1'b0;
      else if (hs_gate_low) hs_seen <= 1'b1;
      if (ls_en)            ls_seen <= 1'b0;
      else if (ls_gate_low) ls_seen <= 1'b1;
    end
  end

  // R1
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(hs_en && ls_en));

  // R2
  hs_after_ls_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_en) |-> ls_seen);

  // R3
  ls_after_hs_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ls_en) |-> hs_seen);

  // R4
  kill_off_chk: assert property (@(posedge clk) disable iff (rst)
    kill |=> (!hs_en && !ls_en));

  // R5
  hold_hs_chk: assert property (@(posedge clk) disable iff (rst)
    (hs_en && pwm_req && !clamp_ls && !kill) |=> hs_en);

  // R5
  hold_ls_chk: assert property (@(posedge clk) disable iff (rst)
    (ls_en && (!pwm_req || clamp_ls) && !kill) |=> ls_en);

  // R6
  clamp_drop_hs_chk: assert property (@(posedge clk) disable iff (rst)
    clamp_ls |=> !hs_en);

  // R8
  stuck_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    stuck |=> (stuck && !hs_en && !ls_en));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!hs_en && !ls_en && !stuck));
endmodule

bind gate_handoff gate_handoff_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .pwm_req    (pwm_req),
  .hs_gate_low(hs_gate_low),
  .ls_gate_low(ls_gate_low),
  .kill       (kill),
  .clamp_ls   (clamp_ls),
  .hs_en      (hs_en),
  .ls_en      (ls_en),
  .stuck      (stuck)
);

// File: tb/gate_handoff_bench.sv
`timescale 1ns/1ps
module gate_handoff_bench;
  localparam int DEAD = 3;
  localparam int TOUT = 10;
  localparam int NROWS = 35;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwm_req = 1'b0, hs_gate_low = 1'b1, ls_gate_low = 1'b1;
  logic kill = 1'b0, clamp_ls = 1'b0;
  logic hs_en, ls_en, stuck;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  gate_handoff #(.DEAD_CYC(DEAD), .TIMEOUT_CYC(TOUT)) u_gate_handoff (
    .clk(clk), .rst(rst), .pwm_req(pwm_req),
    .hs_gate_low(hs_gate_low), .ls_gate_low(ls_gate_low),
    .kill(kill), .clamp_ls(clamp_ls),
    .hs_en(hs_en), .ls_en(ls_en), .stuck(stuck)
  );

  // Row: {rst, pwm, hs_low, ls_low, kill, clamp, exp_hs, exp_ls, exp_stuck}
  // Expected outputs are those after the edge that samples the row inputs.
  localparam logic [8:0] VEC [NROWS] = '{
    9'b1_0_1_1_0_0_000, // 0  R9 reset
    9'b0_0_1_1_0_0_000, // 1  R9 idle -> wait high-side low
    9'b0_0_1_1_0_0_000, // 2  flag seen
    9'b0_0_1_1_0_0_000, // 3  dead 1
    9'b0_0_1_1_0_0_000, // 4  dead 2
    9'b0_0_1_1_0_0_010, // 5  R3 low side on after DEAD
    9'b0_0_1_1_0_0_010, // 6
    9'b0_1_1_0_0_0_000, // 7  R2 ls dropped
    9'b0_1_1_0_0_0_000, // 8  flag still low
    9'b0_1_1_1_0_0_000, // 9  flag seen
    9'b0_1_1_1_0_0_000, // 10
    9'b0_1_1_1_0_0_000, // 11
    9'b0_1_1_1_0_0_100, // 12 R2 high side on
    9'b0_1_0_1_0_0_100, // 13
    9'b0_1_0_1_0_0_100, // 14
    9'b0_0_0_1_0_0_000, // 15 R3 hs dropped
    9'b0_0_1_1_0_0_000, // 16 flag seen, dead starts
    9'b0_1_1_1_0_0_000, // 17 R7 reversal in dead
    9'b0_1_1_1_0_0_000, // 18 restart: flag seen
    9'b0_1_1_1_0_0_000, // 19
    9'b0_1_1_1_0_0_000, // 20
    9'b0_1_1_1_0_0_100, // 21 R7 high side after full restart
    9'b0_1_0_1_0_1_000, // 22 R6 clamp drops hs
    9'b0_1_1_1_0_1_000, // 23
    9'b0_1_1_1_0_1_000, // 24
    9'b0_1_1_1_0_1_000, // 25
    9'b0_1_1_1_0_1_010, // 26 R6 low side on via hand-off
    9'b0_1_1_1_0_1_010, // 27
    9'b0_1_1_1_1_0_000, // 28 R4 kill
    9'b0_1_1_1_1_0_000, // 29 R4 held
    9'b0_1_1_1_0_0_000, // 30 R4 release -> wait
    9'b0_1_1_1_0_0_000, // 31
    9'b0_1_1_1_0_0_000, // 32
    9'b0_1_1_1_0_0_000, // 33
    9'b0_1_1_1_0_0_100  // 34 R4 hand-off complete
  };

  task automatic step(input logic r, p, hl, ll, k, c);
    @(negedge clk);
    rst = r; pwm_req = p; hs_gate_low = hl; ls_gate_low = ll;
    kill = k; clamp_ls = c;
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input logic [2:0] exp);
    logic [2:0] act;
    act = {hs_en, ls_en, stuck};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: {hs,ls,stuck} act=%b exp=%b", tag, act, exp);
    end
    if (hs_en && ls_en) begin
      bad++;
      $display("FAIL R1: both enables high act=%b exp=no overlap", act);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: act=expired exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    bit ok;
    // Vector table (R2 R3 R4 R6 R7 R9)
    for (int i = 0; i < NROWS; i++) begin
      logic [8:0] v;
      v = VEC[i];
      step(v[8], v[7], v[6], v[5], v[4], v[3]);
      chk($sformatf("table row %0d (R2 R3 R4 R6 R7 R9)", i), v[2:0]);
    end

    // R5: 100% duty held for many cycles
    ok = 1'b1;
    for (int i = 0; i < 300; i++) begin
      step(0, 1, 0, 1, 0, 0);
      if (!(hs_en && !ls_en)) ok = 1'b0;
    end
    chk("R5 hold high side", ok ? 3'b100 : 3'b000);

    // R5: 0% duty held for many cycles
    for (int i = 0; i < 10; i++) step(0, 0, 1, 1, 0, 0);
    ok = 1'b1;
    for (int i = 0; i < 300; i++) begin
      step(0, 0, 1, 0, 0, 0);
      if (!(ls_en && !hs_en)) ok = 1'b0;
    end
    chk("R5 hold low side", ok ? 3'b010 : 3'b000);

    // R9: reset while running
    step(1, 0, 1, 1, 0, 0);
    chk("R9 reset while low side on", 3'b000);

    // R8: timeout fault
    step(0, 1, 1, 0, 0, 0);   // enter wait for low-side flag
    chk("R8 wait entered", 3'b000);
    for (int i = 1; i < TOUT; i++) step(0, 1, 1, 0, 0, 0);
    chk("R8 no fault one edge before limit", 3'b000);
    step(0, 1, 1, 0, 0, 0);
    chk("R8 fault at limit", 3'b001);
    ok = 1'b1;
    for (int i = 0; i < 20; i++) begin
      step(0, i[0], 1, 1, i[2], i[1]);
      if (!(stuck && !hs_en && !ls_en)) ok = 1'b0;
    end
    chk("R8 fault sticky under activity", ok ? 3'b001 : 3'b000);
    step(1, 0, 1, 1, 0, 0);
    chk("R9 reset clears stuck", 3'b000);

    // R8 boundary: flag on the last edge before the limit
    step(0, 1, 1, 0, 0, 0);   // entry
    for (int i = 0; i < TOUT - 2; i++) step(0, 1, 1, 0, 0, 0);
    step(0, 1, 1, 1, 0, 0);   // flag arrives at count TOUT-2
    chk("R8 late flag averts fault", 3'b000);
    for (int i = 0; i < DEAD - 1; i++) step(0, 1, 1, 1, 0, 0);
    chk("R2 still in dead time", 3'b000);
    step(0, 1, 1, 1, 0, 0);
    chk("R2 high side after late flag", 3'b100);

    // R4: kill while high side on
    step(0, 1, 0, 1, 1, 0);
    chk("R4 kill from high side", 3'b000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule